// File: doc/BRIEF.md
# IR Scancode Pointer and Key Mapper

This block sits after an infrared frame decoder and takes one scancode word per input strobe. Most codes pass straight through as key events. A code whose fixed marker bits show a stick report carries a small signed X and Y offset and two button bits. The block turns such a report either into a pointer report (mouse mode) or into one of four arrow-key codes (keyboard mode).

The two axis magnitudes are stored with their bits in reverse order across one byte each, and each axis has its own sign bit. One reserved code flips the block between mouse and keyboard mode. Every input code gives one key-event strobe, including toggle codes and stick reports. The key-event strobe carries the final code, which may have been replaced. A separate pointer strobe carries the offsets and buttons. All outputs are registered and appear one clock after the input strobe.

Top module: `ir_ptr_mapper`

## Requirements
- R1: After reset both output strobes are low, all output fields are zero, and the block is in mouse mode.
- R2: Every cycle with `code_valid_i` high gives `key_valid_o` high in the next cycle. `key_valid_o` is low in every other cycle.
- R3: A code is not a stick report when (code AND 0xFC0000FF) differs from 0x680000B7. Such a code appears unchanged on `key_code_o`, and `ptr_valid_o` stays low.
- R4: The code 0x299115B7 inverts the mode, and its key event carries 0x299115B7 unchanged.
- R5: A code is a stick report when (code AND 0xFC0000FF) equals 0x680000B7.
- R6: Within the X byte (code bits [23:16]) and the Y byte (code bits [15:8]), byte bit 3 has weight 8, bit 4 has weight 4, bit 5 has weight 2 and bit 6 has weight 1. Together these form a 4-bit magnitude field m. The other byte bits do not affect the offset.
- R7: Code bit 25 is the X sign and code bit 24 is the Y sign. With the sign set, the offset is m - 16. With the sign clear, the offset is m.
- R8: In mouse mode, a stick report raises `ptr_valid_o` with the X and Y offsets on `ptr_dx_o` and `ptr_dy_o`. `btn_left_o` is code bit 16 and `btn_right_o` is code bit 18. The key event carries the code unchanged.
- R9: In keyboard mode, a stick report with both offsets nonzero replaces the key code according to the axis with the larger absolute value. A tie goes to X. Y positive gives 0x289515B7 and Y negative gives 0x2AA515B7. X positive gives 0x2BA515B7 and X negative gives 0x29A515B7.
- R10: In keyboard mode, a stick report with either offset zero passes through unchanged.
- R11: In keyboard mode no pointer report is ever raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_valid_i | input | 1 | Input scancode strobe |
| code_i | input | 32 | Input scancode |
| key_valid_o | output | 1 | Key event strobe |
| key_code_o | output | 32 | Final key code |
| ptr_valid_o | output | 1 | Pointer report strobe |
| ptr_dx_o | output | AXIS_W | Signed X offset |
| ptr_dy_o | output | AXIS_W | Signed Y offset |
| btn_left_o | output | 1 | Left button state |
| btn_right_o | output | 1 | Right button state |

## Verification
The hard cases are the keyboard-mode steering decisions. They need the hidden mode flag flipped, and they need many signed offset pairs whose magnitudes tie or differ by one, including -16 against 15.

The stimulus covers all 32 x 32 offset pairs in each mode, and sends the toggle code between the two sweeps. The filler bits of each axis byte change with the pair index. This shows that only the four reversed bits set the offset, and that the button bits follow code bits 16 and 18.

// File: rtl/ir_map_pkg.sv
package ir_map_pkg;
  localparam int CODE_W = 32;
  localparam int MAG_W  = 4;
  localparam logic [CODE_W-1:0] STICK_MASK = 32'hFC00_00FF;
  localparam logic [CODE_W-1:0] STICK_PAT  = 32'h6800_00B7;
  localparam logic [CODE_W-1:0] TOGGLE_CODE = 32'h2991_15B7;
  localparam logic [CODE_W-1:0] KEY_DOWN  = 32'h2895_15B7;
  localparam logic [CODE_W-1:0] KEY_UP    = 32'h2AA5_15B7;
  localparam logic [CODE_W-1:0] KEY_RIGHT = 32'h2BA5_15B7;
  localparam logic [CODE_W-1:0] KEY_LEFT  = 32'h29A5_15B7;
  localparam int X_BYTE_LSB = 16;
  localparam int X_SIGN_BIT = 25;
  localparam int BTN_L_BIT  = 16;
  localparam int BTN_R_BIT  = 18;
endpackage

// File: rtl/irmap_axis.sv
module irmap_axis #(
  parameter int AXIS_W = 8
) (
  input  logic [7:0]               byte_i,
  input  logic                     sign_i,
  output logic signed [AXIS_W-1:0] val_o
);
  localparam int EXT_W = AXIS_W - ir_map_pkg::MAG_W;
  logic [ir_map_pkg::MAG_W-1:0] mag;
  // bits 3..6 of the byte carry weights 8,4,2,1
  assign mag   = {byte_i[3], byte_i[4], byte_i[5], byte_i[6]};
  assign val_o = {{EXT_W{sign_i}}, mag};
endmodule

// File: rtl/irmap_steer.sv
module irmap_steer #(
  parameter int AXIS_W = 8
) (
  input  logic signed [AXIS_W-1:0] dx_i,
  input  logic signed [AXIS_W-1:0] dy_i,
  output logic                     both_nz_o,
  output logic [31:0]              arrow_o
);
  import ir_map_pkg::*;
  logic [AXIS_W-1:0] ax, ay;
  assign ax = dx_i[AXIS_W-1] ? AXIS_W'(-dx_i) : AXIS_W'(dx_i);
  assign ay = dy_i[AXIS_W-1] ? AXIS_W'(-dy_i) : AXIS_W'(dy_i);
  assign both_nz_o = (dx_i != '0) && (dy_i != '0);
  always_comb begin
    if (ay > ax) arrow_o = dy_i[AXIS_W-1] ? KEY_UP : KEY_DOWN;
    else         arrow_o = dx_i[AXIS_W-1] ? KEY_LEFT : KEY_RIGHT;
  end
endmodule

// File: rtl/irmap_mode.sv
module irmap_mode (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [31:0] code_i,
  output logic        kbd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kbd_o <= 1'b0;
    else if (valid_i && code_i == ir_map_pkg::TOGGLE_CODE) kbd_o <= ~kbd_o;
  end
endmodule

// File: rtl/ir_ptr_mapper.sv
module ir_ptr_mapper
  import ir_map_pkg::*;
#(
  parameter int AXIS_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     code_valid_i,
  input  logic [CODE_W-1:0]        code_i,
  output logic                     key_valid_o,
  output logic [CODE_W-1:0]        key_code_o,
  output logic                     ptr_valid_o,
  output logic signed [AXIS_W-1:0] ptr_dx_o,
  output logic signed [AXIS_W-1:0] ptr_dy_o,
  output logic                     btn_left_o,
  output logic                     btn_right_o
);
  localparam int N_AXES = 2;

  logic signed [AXIS_W-1:0] axis_val [N_AXES];
  logic kbd_mode, is_stick, both_nz;
  logic [CODE_W-1:0] arrow_code, next_code;

  // axis 0 = X, axis 1 = Y (one byte and one sign bit lower)
  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    irmap_axis #(.AXIS_W(AXIS_W)) u_axis (
      .byte_i (code_i[X_BYTE_LSB - 8*a +: 8]),
      .sign_i (code_i[X_SIGN_BIT - a]),
      .val_o  (axis_val[a])
    );
  end

  irmap_steer #(.AXIS_W(AXIS_W)) u_steer (
    .dx_i      (axis_val[0]),
    .dy_i      (axis_val[1]),
    .both_nz_o (both_nz),
    .arrow_o   (arrow_code)
  );

  irmap_mode u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (code_valid_i),
    .code_i  (code_i),
    .kbd_o   (kbd_mode)
  );

  assign is_stick  = (code_i & STICK_MASK) == STICK_PAT;
  assign next_code = (is_stick && kbd_mode && both_nz) ? arrow_code : code_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_valid_o <= 1'b0;
      key_code_o  <= '0;
      ptr_valid_o <= 1'b0;
      ptr_dx_o    <= '0;
      ptr_dy_o    <= '0;
      btn_left_o  <= 1'b0;
      btn_right_o <= 1'b0;
    end else begin
      key_valid_o <= code_valid_i;
      ptr_valid_o <= code_valid_i && is_stick && !kbd_mode;
      if (code_valid_i) begin
        key_code_o <= next_code;
        if (is_stick && !kbd_mode) begin
          ptr_dx_o    <= axis_val[0];
          ptr_dy_o    <= axis_val[1];
          btn_left_o  <= code_i[BTN_L_BIT];
          btn_right_o <= code_i[BTN_R_BIT];
        end
      end
    end
  end
endmodule

// File: rtl/ir_ptr_mapper_chk.sv
module ir_ptr_mapper_chk
  import ir_map_pkg::*;
#(
  parameter int AXIS_W = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     code_valid_i,
  input logic [CODE_W-1:0]        code_i,
  input logic                     key_valid_o,
  input logic [CODE_W-1:0]        key_code_o,
  input logic                     ptr_valid_o,
  input logic signed [AXIS_W-1:0] ptr_dx_o,
  input logic signed [AXIS_W-1:0] ptr_dy_o,
  input logic                     btn_left_o,
  input logic                     btn_right_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else armed <= 1'b1;
  end

  p_key_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (key_valid_o == $past(code_valid_i)));

  p_pass_through_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(code_valid_i) && (($past(code_i) & STICK_MASK) != STICK_PAT))
      |-> (key_code_o == $past(code_i) && !ptr_valid_o));

  p_ptr_is_stick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_valid_o |-> (key_valid_o && ((key_code_o & STICK_MASK) == STICK_PAT)));

  p_buttons_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_valid_o |-> (btn_left_o == key_code_o[BTN_L_BIT] &&
                     btn_right_o == key_code_o[BTN_R_BIT]));

  p_sign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_valid_o |-> ((ptr_dx_o < 0) == key_code_o[X_SIGN_BIT] &&
                     (ptr_dy_o < 0) == key_code_o[X_SIGN_BIT-1]));

  p_replace_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && key_valid_o && key_code_o != $past(code_i))
      |-> (!ptr_valid_o && (key_code_o == KEY_UP || key_code_o == KEY_DOWN ||
                            key_code_o == KEY_LEFT || key_code_o == KEY_RIGHT)));
endmodule

bind ir_ptr_mapper ir_ptr_mapper_chk #(.AXIS_W(AXIS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .code_valid_i(code_valid_i), .code_i(code_i),
  .key_valid_o(key_valid_o), .key_code_o(key_code_o), .ptr_valid_o(ptr_valid_o),
  .ptr_dx_o(ptr_dx_o), .ptr_dy_o(ptr_dy_o), .btn_left_o(btn_left_o),
  .btn_right_o(btn_right_o)
);

// File: tb/ir_ptr_mapper_tb.sv
module ir_ptr_mapper_tb;
  localparam int AXIS_W = 8;
  localparam logic [31:0] TOG = 32'h2991_15B7;

  logic clk = 0, rst_ni = 0, code_valid_i = 0;
  logic [31:0] code_i = '0;
  logic key_valid_o, ptr_valid_o, btn_left_o, btn_right_o;
  logic [31:0] key_code_o;
  logic signed [AXIS_W-1:0] ptr_dx_o, ptr_dy_o;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ir_ptr_mapper #(.AXIS_W(AXIS_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .code_valid_i(code_valid_i), .code_i(code_i),
    .key_valid_o(key_valid_o), .key_code_o(key_code_o), .ptr_valid_o(ptr_valid_o),
    .ptr_dx_o(ptr_dx_o), .ptr_dy_o(ptr_dy_o), .btn_left_o(btn_left_o),
    .btn_right_o(btn_right_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one strobe at a falling edge, sample at the next falling edge
  task automatic send(input logic [31:0] c);
    @(negedge clk);
    code_valid_i = 1; code_i = c;
    @(negedge clk);
    code_valid_i = 0;
  endtask

  function automatic logic [31:0] stick_code(input int i, output int dx, output int dy,
                                             output bit bl, output bit br);
    logic [4:0] xv = 5'(i), yv = 5'(i >> 5);
    logic [3:0] fx = 4'(i * 7 + 3), fy = 4'(i * 5 + 1);
    logic [7:0] bx = {fx[3], xv[0], xv[1], xv[2], xv[3], fx[2], fx[1], fx[0]};
    logic [7:0] by = {fy[3], yv[0], yv[1], yv[2], yv[3], fy[2], fy[1], fy[0]};
    dx = xv[4] ? int'(xv[3:0]) - 16 : int'(xv[3:0]);
    dy = yv[4] ? int'(yv[3:0]) - 16 : int'(yv[3:0]);
    bl = bx[0]; br = bx[2];
    return 32'h6800_00B7 | (32'(xv[4]) << 25) | (32'(yv[4]) << 24) |
           (32'(bx) << 16) | (32'(by) << 8);
  endfunction

  task automatic final_report;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    for (int w = 0; w < 150000; w++) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      final_report();
    end
  end

  initial begin
    logic [31:0] misc [6] = '{32'h0000_0000, 32'h6C00_00B7, 32'h6800_00B6,
                              32'hE800_00B7, 32'h1234_5678, 32'h2895_15B7};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 key_valid", key_valid_o, 0);
    chk("R1 ptr_valid", ptr_valid_o, 0);
    chk("R1 key_code", key_code_o, 0);
    chk("R1 dx", ptr_dx_o, 0);
    rst_ni = 1;
    @(negedge clk);
    chk("R2 idle no key", key_valid_o, 0);

    // R3: near-miss and unrelated codes pass unchanged
    foreach (misc[k]) begin
      send(misc[k]);
      chk("R3 key_valid", key_valid_o, 1);
      chk("R3 key_code", key_code_o, misc[k]);
      chk("R3 no ptr", ptr_valid_o, 0);
    end
    @(negedge clk);
    chk("R2 strobe one cycle", key_valid_o, 0);

    // mouse-mode sweep (R1 mode after reset, R5..R8)
    for (int i = 0; i < 1024; i++) begin
      int dx, dy; bit bl, br;
      logic [31:0] c = stick_code(i, dx, dy, bl, br);
      send(c);
      chk("R2 key_valid", key_valid_o, 1);
      chk("R8 code unchanged", key_code_o, c);
      chk("R5 R8 ptr_valid", ptr_valid_o, 1);
      chk("R6 R7 dx", longint'(ptr_dx_o), dx);
      chk("R6 R7 dy", longint'(ptr_dy_o), dy);
      chk("R8 btn_left", btn_left_o, bl);
      chk("R8 btn_right", btn_right_o, br);
    end

    // R4: toggle into keyboard mode
    send(TOG);
    chk("R4 toggle key_code", key_code_o, TOG);
    chk("R4 toggle no ptr", ptr_valid_o, 0);

    for (int i = 0; i < 1024; i++) begin
      int dx, dy, ax, ay; bit bl, br;
      logic [31:0] c = stick_code(i, dx, dy, bl, br), e;
      ax = dx < 0 ? -dx : dx;
      ay = dy < 0 ? -dy : dy;
      if (dx == 0 || dy == 0) e = c;                        // R10
      else if (ay > ax) e = dy > 0 ? 32'h2895_15B7 : 32'h2AA5_15B7;
      else e = dx > 0 ? 32'h2BA5_15B7 : 32'h29A5_15B7;       // R9 ties to X
      send(c);
      chk("R9 R10 key_code", key_code_o, e);
      chk("R11 no ptr", ptr_valid_o, 0);
    end

    // R4: toggle back into mouse mode
    send(TOG);
    chk("R4 toggle back code", key_code_o, TOG);
    begin
      int dx, dy; bit bl, br;
      logic [31:0] c = stick_code(37, dx, dy, bl, br);
      send(c);
      chk("R4 mouse again ptr", ptr_valid_o, 1);
      chk("R4 mouse again code", key_code_o, c);
    end

    done = 1;
    final_report();
  end
endmodule